// File: doc/BRIEF.md
# Two-Byte Command I2C Master

This block is an I2C bus master that a host controls through six 16-bit registers. The host places up to two outgoing bytes in a transmit register and then writes a command word. The command word names a 7-bit target, a direction, one or two data bytes, and whether the bus is released at the end. Each accepted command runs one transaction. It opens with a START, or with a repeated START when the previous command kept the bus. It then sends the address byte with the read/write bit, moves the data bytes, and closes with a STOP. If the command asked to keep the bus, the STOP is left out and SCL is parked low.

A longer message is built from a chain of such commands, each one holding the bus for the next. The outcome of each command is reported in a status register: receive done, transmit done, or error. Each status bit is cleared by writing a one to it. Each bit has a matching enable, and the enabled bits together drive a level interrupt. A one-byte read to an absent target serves as a presence probe and ends with the error bit. SCL and SDA are open-drain: the block only ever pulls a line low or releases it. The SCL rate comes from a parameterised divider of the system clock.

Top module: `mbi2c_master`

## Requirements
- R1: After reset, all registers read 0x0000, both line drivers are released (scl_oe = sda_oe = 0) and irq is low.
- R2: A write command (command bit 10 = 1, bits 15:14 = 2) issues a START, the address byte {bits 7:1, R/W = 0}, and then one data byte (bit 11 = 0) or two (bit 11 = 1) taken from transmit register 0x04, bits 7:0 first and bits 15:8 second. It then issues a STOP and sets status bit 14 (register 0x00).
- R3: A read command (bit 10 = 0) sends R/W = 1. The first received byte lands in bits 7:0 of register 0x08 and the second in bits 15:8; bits 15:8 read 0 after a one-byte read. Status bit 15 is set when the data is valid.
- R4: During reads the master drives ACK (SDA low) after every received byte except the last byte of the command, which it NACKs (SDA released).
- R5: An address byte that is not acknowledged sets status bit 13 and neither bit 14 nor bit 15. A STOP follows, and register 0x08 keeps its old value.
- R6: A NACK on a written data byte sets bit 13, skips the remaining byte and issues a STOP, even when command bit 13 (keep bus) is set.
- R7: With command bit 13 set, no STOP is issued and SCL stays driven low after completion. The next command begins with a repeated START, with no STOP in between.
- R8: A command written while a transaction is running has no effect. A command whose bits 15:14 differ from 2 also has no effect. Register 0x0A reads back the most recently accepted command word.
- R9: Writing a one to a status bit clears it and writing zero leaves it. A completion event in the same cycle as a clear of its bit leaves the bit set.
- R10: irq is high exactly when some status bit 15:13 is set together with the same bit of the enable register 0x02.
- R11: SCL high and low times are each 2*CLK_DIV clock cycles. SCL and SDA never change in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| scl_i | input | 1 | Sensed level of SCL |
| sda_i | input | 1 | Sensed level of SDA |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| irq | output | 1 | Level interrupt |

## Verification
The two functions that can fall in the same cycle are the engine's completion event, which sets a status bit, and a host write-one-to-clear of that same bit. To force the overlap, the bench keeps a clear of all status bits active on every cycle while a transmit runs to its end. A clear that wins would hide the event entirely. The rule that the set wins is judged by the interrupt output, with transmit done enabled: it must be seen high for exactly one cycle and then read clear.

// File: rtl/mbi2c_pkg.sv
`timescale 1ns/1ps
package mbi2c_pkg;
  localparam int DATA_W = 16;

  localparam logic [3:0] OFS_STAT  = 4'h0;
  localparam logic [3:0] OFS_IEN   = 4'h2;
  localparam logic [3:0] OFS_TXD   = 4'h4;
  localparam logic [3:0] OFS_CMD   = 4'h6;
  localparam logic [3:0] OFS_RXD   = 4'h8;
  localparam logic [3:0] OFS_CMDRB = 4'hA;

  localparam int EVT_LSB  = 13;
  localparam int CMD_WR   = 10;
  localparam int CMD_TWO  = 11;
  localparam int CMD_KEEP = 13;
  localparam logic [1:0] MODE_NATIVE = 2'd2;

  typedef enum logic [2:0] {
    EN_IDLE,
    EN_START,
    EN_BIT,
    EN_STOP,
    EN_HOLD
  } eng_state_t;
endpackage

// File: rtl/mbi2c_clkdiv.sv
`timescale 1ns/1ps
module mbi2c_clkdiv #(
  parameter int CLK_DIV = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int DIV_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(CLK_DIV - 1);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mbi2c_engine.sv
`timescale 1ns/1ps
module mbi2c_engine
  import mbi2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [6:0]        tgt_addr,
  input  logic              is_read,
  input  logic              two_bytes,
  input  logic              keep_bus,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              tick,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              busy,
  output logic              held,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              done,
  output logic              done_err,
  output logic              done_rd,
  output logic [DATA_W-1:0] rx_word
);
  eng_state_t        st_q, st_d;
  logic [1:0]        ph_q, ph_d;
  logic [3:0]        bit_q, bit_d;
  logic [1:0]        byte_q, byte_d;
  logic [7:0]        sh_q, sh_d;
  logic              rd_q, rd_d, two_q, two_d, keep_q, keep_d, err_q, err_d;
  logic              nack_q, nack_d, held_q, held_d;
  logic              scl_low_q, scl_low_d, sda_low_q, sda_low_d;
  logic [DATA_W-1:0] tx_q, tx_d, rx_q, rx_d;

  logic       stall, adv, tx_byte, bit_rel;
  logic [1:0] last_byte;

  assign busy      = (st_q != EN_IDLE);
  assign held      = held_q;
  assign scl_oe    = scl_low_q;
  assign sda_oe    = sda_low_q;
  assign done_err  = err_q;
  assign done_rd   = rd_q;
  assign rx_word   = rx_q;

  assign last_byte = two_q ? 2'd2 : 2'd1;
  assign tx_byte   = (byte_q == 2'd0) || !rd_q;
  assign stall     = (st_q == EN_BIT) && (ph_q == 2'd2) && !scl_i;
  assign adv       = tick && !stall;

  always_comb begin
    if (bit_q != 4'd8) bit_rel = tx_byte ? sh_q[7] : 1'b1;
    else               bit_rel = tx_byte ? 1'b1 : (byte_q == last_byte);
  end

  always_comb begin
    st_d = st_q;   ph_d = ph_q;   bit_d = bit_q;   byte_d = byte_q;
    sh_d = sh_q;   rd_d = rd_q;   two_d = two_q;   keep_d = keep_q;
    err_d = err_q; tx_d = tx_q;   rx_d = rx_q;     nack_d = nack_q;
    held_d = held_q;
    scl_low_d = scl_low_q;
    sda_low_d = sda_low_q;
    done = 1'b0;
    case (st_q)
      EN_IDLE: begin
        if (launch) begin
          st_d = EN_START; ph_d = '0; bit_d = '0; byte_d = '0;
          sh_d = {tgt_addr, is_read};
          rd_d = is_read; two_d = two_bytes; keep_d = keep_bus;
          err_d = 1'b0; tx_d = tx_word; rx_d = '0; held_d = 1'b0;
          sda_low_d = 1'b0;
        end
      end
      EN_START: begin
        if (adv) begin
          ph_d = ph_q + 2'd1;
          case (ph_q)
            2'd0: scl_low_d = 1'b0;
            2'd1: sda_low_d = 1'b1;
            2'd2: ;
            default: begin
              st_d = EN_BIT;
              scl_low_d = 1'b1;
            end
          endcase
        end
      end
      EN_BIT: begin
        if (adv) begin
          ph_d = ph_q + 2'd1;
          case (ph_q)
            2'd0: sda_low_d = ~bit_rel;
            2'd1: scl_low_d = 1'b0;
            2'd2: begin
              if (bit_q == 4'd8) nack_d = sda_i;
              else if (!tx_byte) sh_d = {sh_q[6:0], sda_i};
            end
            default: begin
              scl_low_d = 1'b1;
              if (bit_q != 4'd8) begin
                bit_d = bit_q + 4'd1;
                if (tx_byte) sh_d = {sh_q[6:0], 1'b0};
              end else begin
                bit_d = '0;
                if (!tx_byte) begin
                  if (byte_q == 2'd1) rx_d[7:0]  = sh_q;
                  else                rx_d[15:8] = sh_q;
                end
                if (tx_byte && nack_q) begin
                  err_d = 1'b1;
                  st_d  = EN_STOP;
                end else if (byte_q == last_byte) begin
                  st_d = keep_q ? EN_HOLD : EN_STOP;
                end else begin
                  byte_d = byte_q + 2'd1;
                  if (!rd_q) sh_d = (byte_q == 2'd0) ? tx_q[7:0] : tx_q[15:8];
                end
              end
            end
          endcase
        end
      end
      EN_STOP: begin
        if (adv) begin
          ph_d = ph_q + 2'd1;
          case (ph_q)
            2'd0: sda_low_d = 1'b1;
            2'd1: scl_low_d = 1'b0;
            2'd2: sda_low_d = 1'b0;
            default: begin
              st_d = EN_IDLE;
              done = 1'b1;
            end
          endcase
        end
      end
      EN_HOLD: begin
        if (adv) begin
          if (ph_q == 2'd1) begin
            st_d = EN_IDLE; ph_d = '0; held_d = 1'b1; done = 1'b1;
          end else begin
            ph_d = ph_q + 2'd1;
            sda_low_d = 1'b0;
          end
        end
      end
      default: st_d = EN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= EN_IDLE; ph_q <= '0; bit_q <= '0; byte_q <= '0; sh_q <= '0;
      rd_q <= 1'b0; two_q <= 1'b0; keep_q <= 1'b0; err_q <= 1'b0;
      tx_q <= '0; rx_q <= '0; nack_q <= 1'b0; held_q <= 1'b0;
      scl_low_q <= 1'b0; sda_low_q <= 1'b0;
    end else begin
      st_q <= st_d; ph_q <= ph_d; bit_q <= bit_d; byte_q <= byte_d; sh_q <= sh_d;
      rd_q <= rd_d; two_q <= two_d; keep_q <= keep_d; err_q <= err_d;
      tx_q <= tx_d; rx_q <= rx_d; nack_q <= nack_d; held_q <= held_d;
      scl_low_q <= scl_low_d; sda_low_q <= sda_low_d;
    end
  end
endmodule

// File: rtl/mbi2c_regs.sv
`timescale 1ns/1ps
module mbi2c_regs
  import mbi2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic              done_err,
  input  logic              done_rd,
  input  logic [DATA_W-1:0] rx_word,
  output logic              launch,
  output logic [DATA_W-1:0] cmd_q,
  output logic [DATA_W-1:0] txd_q,
  output logic [2:0]        stat_q,
  output logic [2:0]        ien_q,
  output logic              irq
);
  logic [DATA_W-1:0] cmd_d, txd_d, rxd_q, rxd_d;
  logic [2:0]        stat_d, ien_d, evt_set, evt_clr;
  logic              wr_stat, wr_ien, wr_txd, wr_cmd;

  assign wr_stat = reg_we && (reg_addr == OFS_STAT);
  assign wr_ien  = reg_we && (reg_addr == OFS_IEN);
  assign wr_txd  = reg_we && (reg_addr == OFS_TXD);
  assign wr_cmd  = reg_we && (reg_addr == OFS_CMD);

  assign launch  = wr_cmd && !busy && (reg_wdata[15:14] == MODE_NATIVE);
  assign evt_set = done ? {done_rd && !done_err, !done_rd && !done_err, done_err} : 3'b000;
  assign evt_clr = wr_stat ? reg_wdata[EVT_LSB+2:EVT_LSB] : 3'b000;
  assign irq     = |(stat_q & ien_q);

  always_comb begin
    stat_d = (stat_q & ~evt_clr) | evt_set;
    ien_d  = wr_ien ? reg_wdata[EVT_LSB+2:EVT_LSB] : ien_q;
    txd_d  = wr_txd ? reg_wdata : txd_q;
    cmd_d  = launch ? reg_wdata : cmd_q;
    rxd_d  = (done && done_rd && !done_err) ? rx_word : rxd_q;
  end

  always_comb begin
    case (reg_addr)
      OFS_STAT:  reg_rdata = {stat_q, {EVT_LSB{1'b0}}};
      OFS_IEN:   reg_rdata = {ien_q, {EVT_LSB{1'b0}}};
      OFS_TXD:   reg_rdata = txd_q;
      OFS_RXD:   reg_rdata = rxd_q;
      OFS_CMDRB: reg_rdata = cmd_q;
      default:   reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0; ien_q <= '0; txd_q <= '0; cmd_q <= '0; rxd_q <= '0;
    end else begin
      stat_q <= stat_d; ien_q <= ien_d; txd_q <= txd_d; cmd_q <= cmd_d; rxd_q <= rxd_d;
    end
  end
endmodule

// File: rtl/mbi2c_master.sv
`timescale 1ns/1ps
module mbi2c_master
  import mbi2c_pkg::*;
#(
  parameter int CLK_DIV = 125
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  reg_addr,
  input  logic        reg_we,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        scl_oe,
  output logic        sda_oe,
  output logic        irq
);
  logic              busy, held, done, done_err, done_rd, launch, tick;
  logic [DATA_W-1:0] rx_word, cmd_q, txd_q;
  logic [2:0]        stat_q, ien_q;

  mbi2c_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .done(done),
    .done_err(done_err), .done_rd(done_rd), .rx_word(rx_word), .launch(launch),
    .cmd_q(cmd_q), .txd_q(txd_q), .stat_q(stat_q), .ien_q(ien_q), .irq(irq)
  );

  mbi2c_clkdiv #(.CLK_DIV(CLK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
  );

  mbi2c_engine u_eng (
    .clk(clk), .rst_n(rst_n), .launch(launch),
    .tgt_addr(reg_wdata[7:1]), .is_read(!reg_wdata[CMD_WR]),
    .two_bytes(reg_wdata[CMD_TWO]), .keep_bus(reg_wdata[CMD_KEEP]),
    .tx_word(txd_q), .tick(tick), .scl_i(scl_i), .sda_i(sda_i),
    .busy(busy), .held(held), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .done(done), .done_err(done_err), .done_rd(done_rd), .rx_word(rx_word)
  );
endmodule

// File: rtl/mbi2c_master_chk.sv
`timescale 1ns/1ps
module mbi2c_master_chk
  import mbi2c_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  reg_addr,
  input logic        reg_we,
  input logic [15:0] reg_wdata,
  input logic        scl_oe,
  input logic        sda_oe,
  input logic        irq,
  input logic        busy,
  input logic        held,
  input logic        done,
  input logic        done_err,
  input logic        done_rd,
  input logic [15:0] cmd_q,
  input logic [2:0]  stat_q,
  input logic [2:0]  ien_q
);
  AST_RELEASED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !held) |-> (!scl_oe && !sda_oe)); // R1

  AST_CMD_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_addr == OFS_CMD && reg_wdata[15:14] == MODE_NATIVE) |=> $stable(cmd_q)); // R8

  AST_ERR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_err) |=> !held); // R6

  AST_HELD_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> scl_oe); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_err && done_rd) |=> stat_q[2]); // R9

  AST_IRQ_OFF_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == 3'b000) |-> !irq); // R10

  AST_ONE_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(!$stable(scl_oe) && !$stable(sda_oe))); // R11
endmodule

bind mbi2c_master mbi2c_master_chk u_chk (.*);

// File: tb/mbi2c_master_bench.sv
`timescale 1ns/1ps
module mbi2c_master_bench;
  localparam int DIV = 5;
  localparam logic [6:0] SLV = 7'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] reg_addr = 4'h0;
  logic reg_we = 1'b0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic scl_oe, sda_oe, irq;
  logic sl_sda_low = 1'b0;
  wire scl = !scl_oe;
  wire sda = !(sda_oe || sl_sda_low);

  always #2.5 clk = ~clk;

  mbi2c_master #(.CLK_DIV(DIV)) u_mbi2c_master (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_i(scl), .sda_i(sda),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
  );

  int errors = 0, checks = 0, n_start = 0, n_stop = 0;
  bit fin = 1'b0;

  // target model
  int bc = 0;
  bit active = 0, addr_phase = 0, rd_mode = 0, mack = 0, nack_data = 0;
  logic [7:0] sh = 8'h0, txb = 8'h0;
  logic [7:0] wlog [8];
  logic [7:0] rsrc [4];
  bit mlog [8];
  int nw = 0, ridx = 0, nm = 0;

  always @(negedge sda) if (scl) begin
    n_start++; active = 1; addr_phase = 1; rd_mode = 0; bc = -1; sl_sda_low = 0;
  end
  always @(posedge sda) if (scl) begin
    n_stop++; active = 0;
  end
  always @(posedge scl) if (active) begin
    if (bc >= 0 && bc < 8) sh = {sh[6:0], sda};
    else if (bc == 8 && rd_mode && !addr_phase) begin
      mack = !sda;
      if (nm < 8) mlog[nm] = mack;
      nm++;
    end
  end
  always @(negedge scl) if (active) begin
    bc = bc + 1;
    if (bc == 8) begin
      if (addr_phase) begin
        if (sh[7:1] == SLV) begin rd_mode = sh[0]; sl_sda_low = 1; end
        else begin sl_sda_low = 0; active = 0; end
      end else if (!rd_mode) begin
        if (nw < 8) wlog[nw] = sh;
        nw++;
        sl_sda_low = !nack_data;
      end else sl_sda_low = 0;
    end else if (bc == 9) begin
      bc = 0;
      if (rd_mode && (addr_phase || mack)) begin
        txb = rsrc[ridx % 4]; ridx++; sl_sda_low = !txb[7];
      end else sl_sda_low = 0;
      addr_phase = 0;
    end else if (rd_mode && !addr_phase && bc > 0 && bc < 8) sl_sda_low = !txb[7-bc];
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk); reg_addr = a; #0.5; v = reg_rdata;
  endtask

  task automatic wait_done(output logic [15:0] s);
    s = 16'h0;
    for (int i = 0; i < 6000 && s == 16'h0; i++) reg_read(4'h0, s);
  endtask

  function automatic logic [15:0] mk(input logic [6:0] a, input bit wr, input bit two, input bit keep);
    return 16'h8000 | (16'(keep) << 13) | (16'(two) << 11) | (16'(wr) << 10) | {8'h0, a, 1'b0};
  endfunction

  task automatic t_reset;
    logic [15:0] v;
    reg_read(4'h0, v); chk("R1 status", v, 16'h0);
    reg_read(4'h2, v); chk("R1 enable", v, 16'h0);
    reg_read(4'h8, v); chk("R1 rx", v, 16'h0);
    reg_read(4'hA, v); chk("R1 cmd readback", v, 16'h0);
    chk("R1 lines/irq", {13'h0, scl_oe, sda_oe, irq}, 16'h0);
  endtask

  task automatic t_write(input logic [15:0] d, input bit two);
    logic [15:0] s; int s0, p0;
    nw = 0; s0 = n_start; p0 = n_stop;
    reg_write(4'h4, d);
    reg_write(4'h6, mk(SLV, 1, two, 0));
    wait_done(s);
    chk("R2 status tx", s, 16'h4000);
    chk("R2 byte count", 16'(nw), two ? 16'd2 : 16'd1);
    chk("R2 first byte", {8'h0, wlog[0]}, {8'h0, d[7:0]});
    if (two) chk("R2 second byte", {8'h0, wlog[1]}, {8'h0, d[15:8]});
    chk("R2 start/stop", 16'((n_start - s0) * 16 + (n_stop - p0)), 16'h11);
    reg_write(4'h0, 16'hE000);
  endtask

  task automatic t_read(input logic [7:0] b0, input logic [7:0] b1, input bit two);
    logic [15:0] s, v;
    rsrc[0] = b0; rsrc[1] = b1; ridx = 0; nm = 0;
    reg_write(4'h6, mk(SLV, 0, two, 0));
    wait_done(s);
    chk("R3 status rx", s, 16'h8000);
    reg_read(4'h8, v);
    chk("R3 rx data", v, two ? {b1, b0} : {8'h0, b0});
    chk("R4 ack count", 16'(nm), two ? 16'd2 : 16'd1);
    if (two) chk("R4 ack first", {15'h0, mlog[0]}, 16'h1);
    chk("R4 nack last", {15'h0, mlog[two ? 1 : 0]}, 16'h0);
    reg_write(4'h0, 16'hE000);
  endtask

  task automatic t_probe;
    logic [15:0] s, v, r0; int p0;
    reg_read(4'h8, r0); p0 = n_stop;
    reg_write(4'h6, mk(7'h21, 0, 0, 0));
    wait_done(s);
    chk("R5 status err", s, 16'h2000);
    chk("R5 stop", 16'(n_stop - p0), 16'd1);
    reg_read(4'h8, v); chk("R5 rx kept", v, r0);
    reg_write(4'h0, 16'hE000);
  endtask

  task automatic t_data_nack;
    logic [15:0] s; int p0;
    nack_data = 1; nw = 0; p0 = n_stop;
    reg_write(4'h4, 16'h2211);
    reg_write(4'h6, mk(SLV, 1, 1, 1));
    wait_done(s);
    nack_data = 0;
    chk("R6 status err", s, 16'h2000);
    chk("R6 bytes sent", 16'(nw), 16'd1);
    chk("R6 stop despite keep", 16'(n_stop - p0), 16'd1);
    @(negedge clk); chk("R6 bus released", {15'h0, scl_oe}, 16'h0);
    reg_write(4'h0, 16'hE000);
  endtask

  task automatic t_hold_chain;
    logic [15:0] s, v; int s0, p0;
    s0 = n_start; p0 = n_stop;
    reg_write(4'h4, 16'h0011);
    reg_write(4'h6, mk(SLV, 1, 0, 1));
    wait_done(s);
    chk("R7 held tx status", s, 16'h4000);
    chk("R7 no stop", 16'(n_stop - p0), 16'd0);
    repeat (20) @(negedge clk);
    chk("R7 scl parked low", {15'h0, scl_oe}, 16'h1);
    reg_write(4'h0, 16'hE000);
    rsrc[0] = 8'h5A; ridx = 0; nm = 0;
    reg_write(4'h6, mk(SLV, 0, 0, 0));
    wait_done(s);
    chk("R7 chained rx status", s, 16'h8000);
    chk("R7 repeated start", 16'((n_start - s0) * 16 + (n_stop - p0)), 16'h21);
    reg_read(4'h8, v); chk("R7 chained rx data", v, 16'h005A);
    chk("R7 released after", {15'h0, scl_oe}, 16'h0);
    reg_write(4'h0, 16'hE000);
  endtask

  task automatic t_busy_and_mode;
    logic [15:0] s, v, ca; int s0;
    ca = mk(SLV, 1, 0, 0); nw = 0;
    reg_write(4'h4, 16'h0042);
    reg_write(4'h6, ca);
    repeat (30) @(negedge clk);
    reg_write(4'h6, mk(SLV, 0, 1, 0));
    reg_read(4'hA, v); chk("R8 busy cmd ignored", v, ca);
    wait_done(s);
    chk("R8 only first ran", s, 16'h4000);
    chk("R8 one byte", 16'(nw), 16'd1);
    reg_write(4'h0, 16'hE000);
    s0 = n_start;
    reg_write(4'h6, 16'h4000 | {8'h0, SLV, 1'b0});
    repeat (300) @(negedge clk);
    reg_read(4'hA, v); chk("R8 bad mode readback", v, ca);
    chk("R8 bad mode no start", 16'(n_start - s0), 16'd0);
    reg_read(4'h0, v); chk("R8 bad mode status", v, 16'h0);
  endtask

  task automatic t_w1c_irq;
    logic [15:0] s, v;
    reg_write(4'h4, 16'h0099);
    reg_write(4'h6, mk(SLV, 1, 0, 0));
    wait_done(s);
    chk("R10 irq masked", {15'h0, irq}, 16'h0);
    reg_write(4'h2, 16'h4000); @(negedge clk);
    chk("R10 irq enabled", {15'h0, irq}, 16'h1);
    reg_write(4'h2, 16'hA000); @(negedge clk);
    chk("R10 irq other enables", {15'h0, irq}, 16'h0);
    reg_write(4'h0, 16'hA000);
    reg_read(4'h0, v); chk("R9 zero keeps", v, 16'h4000);
    reg_write(4'h0, 16'h4000);
    reg_read(4'h0, v); chk("R9 one clears", v, 16'h0);
    reg_write(4'h2, 16'h0000);
  endtask

  task automatic t_collision;
    logic [15:0] v; int seen;
    seen = 0;
    reg_write(4'h2, 16'hE000);
    reg_write(4'h4, 16'h0055);
    reg_write(4'h6, mk(SLV, 1, 0, 0));
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (irq) seen++;
      reg_addr = 4'h0; reg_wdata = 16'hE000; reg_we = 1'b1;
    end
    @(negedge clk); reg_we = 1'b0;
    chk("R9 set wins over clear", 16'(seen), 16'd1);
    reg_read(4'h0, v); chk("R9 cleared after", v, 16'h0);
    reg_write(4'h2, 16'h0000);
  endtask

  task automatic t_timing;
    logic [15:0] s; int n;
    reg_write(4'h4, 16'h00F0);
    reg_write(4'h6, mk(SLV, 1, 0, 0));
    @(posedge scl); @(negedge clk);
    n = 0;
    while (scl) begin n++; @(negedge clk); end
    chk("R11 scl high time", 16'(n), 16'(2 * DIV));
    n = 0;
    while (!scl) begin n++; @(negedge clk); end
    chk("R11 scl low time", 16'(n), 16'(2 * DIV));
    wait_done(s);
    reg_write(4'h0, 16'hE000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_write(16'h3CA5, 1);
    t_write(16'h0077, 0);
    t_read(8'h96, 8'h1F, 1);
    t_read(8'hC3, 8'h00, 0);
    t_probe;
    t_data_nack;
    t_hold_chain;
    t_busy_and_mode;
    t_w1c_irq;
    t_collision;
    t_timing;
    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule